// File: doc/BRIEF.md
# Configurable Logic Cell Register Stage

This block is the storage and signal-steering slice of a programmable logic cell. It takes three lookup-table result bits (F, G, H), four general control inputs, one cell clock and a global set/reset. It produces two registered outputs, two combinational outputs, and the four internal control signals it has routed from the general inputs. Each of the two storage elements is shaped by static configuration bits:
- capture edge;
- set-or-reset value;
- data source;
- edge-triggered or level-sensitive operation;
- whether its enable and set/reset inputs are connected.

Configuration is one parallel word. A level-held configuration register takes that word only while a load strobe is high. A power-up input returns the whole configuration to its all-zero default. The all-zero default routes general input 0 to every control and selects F for X and for both elements, G for Y. It gives rising-edge flip-flops that reset to 0, with the enable and set/reset left unconnected. A system normally loads the configuration with the clock idle and then pulses global set/reset, so that both elements start from their configured values.

Top module: `lcell_regstage`

## Requirements
- R1: While `por_n` is low the configuration is all zero. Both `reg_q` bits read 0, even across clock edges. `out_x` equals F, `out_y` equals G, and all four routed controls equal `gp_ctl[0]`.
- R2: In flip-flop mode with the edge bit 0, an element loads its selected data on a rising edge of `cell_clk` and ignores falling edges.
- R3: With the edge bit 1, an element loads on falling edges of `cell_clk` and ignores rising edges.
- R4: An element's data-source field selects its data: 0 selects F, 1 selects G, 2 selects H and 3 selects the routed direct-data control.
- R5: When the enable-connected bit is 1, a clock edge loads the element only while the routed enable is high. When that bit is 0, the element is always enabled, whatever the general inputs are.
- R6: When the set/reset-connected bit is 1, a high routed set/reset forces the element at once, with no clock edge, to 1 if its set bit is 1 and to 0 if it is 0. It holds that value over clock edges until it is released. When the set/reset-connected bit is 0, the routed set/reset has no effect.
- R7: A high `gsr` forces each element at once to its own set-bit value. It holds that value through clock edges.
- R8: With the latch bit 1, the element is transparent while the clock (inverted when the edge bit is 1) is high and the element is enabled. It holds its value otherwise.
- R9: `out_x` is F when the X-select bit is 0 and H when it is 1. `out_y` is G when the Y-select bit is 0 and H when it is 1.
- R10: Each of the four routed controls (`ctl_h1`, `ctl_din`, `ctl_sr`, `ctl_ec`) equals `gp_ctl[s]`, where s is that control's own 2-bit selector.
- R11: Changes on `cfg_word` while `cfg_load` is low do not alter the configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| por_n | input | 1 | Power-up, active low; clears configuration and elements |
| cfg_load | input | 1 | Configuration strobe; register transparent while high |
| cfg_word | input | CFG_W (24) | Parallel configuration word (layout of `cell_cfg_t`) |
| cell_clk | input | 1 | Cell clock shared by both elements |
| gsr | input | 1 | Global set/reset, active high, asynchronous |
| lut_f | input | 1 | F lookup-table result |
| lut_g | input | 1 | G lookup-table result |
| lut_h | input | 1 | H lookup-table result |
| gp_ctl | input | 4 | General control inputs |
| out_x | output | 1 | Combinational X output |
| out_y | output | 1 | Combinational Y output |
| reg_q | output | 2 | Storage element outputs, bit 0 is element 0 |
| ctl_h1 | output | 1 | Routed H1 control |
| ctl_din | output | 1 | Routed direct-data control |
| ctl_sr | output | 1 | Routed set/reset control |
| ctl_ec | output | 1 | Routed clock-enable control |

## Verification
A wrong edge bit or a wrong data-source select inside an element shows on `reg_q` half a clock period after the first edge that should or should not have loaded. A wrong set bit or a dropped set/reset connection shows on `reg_q` with no clock at all, as soon as `gsr` or the routed set/reset rises. Faults in the selectors or the configuration register are purely combinational and show on `out_x`, `out_y` or the routed controls as soon as the inputs settle. For that reason the checks sample each output one half-period after the stimulus that should have moved it.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int NUM_GP   = 4;
    localparam int GP_SEL_W = $clog2(NUM_GP);
    localparam int NUM_ELEM = 2;

    // data source for one storage element
    typedef enum logic [1:0] {
        DSRC_F   = 2'd0,
        DSRC_G   = 2'd1,
        DSRC_H   = 2'd2,
        DSRC_DIN = 2'd3
    } dsrc_e;

    // per-element static configuration; all-zero is the default element
    typedef struct packed {
        logic  edge_neg;  // 1: capture on falling edge / transparent on low clock
        logic  sr_set;    // 1: set/reset forces 1, 0: forces 0
        dsrc_e dsel;
        logic  latch;     // 1: level-sensitive latch
        logic  ec_conn;   // 0: enable unconnected, element always enabled
        logic  sr_conn;   // 0: set/reset unconnected, inactive
    } elem_cfg_t;

    typedef struct packed {
        logic [GP_SEL_W-1:0] sel_h1;
        logic [GP_SEL_W-1:0] sel_din;
        logic [GP_SEL_W-1:0] sel_sr;
        logic [GP_SEL_W-1:0] sel_ec;
        logic                xsel;   // 0: F, 1: H
        logic                ysel;   // 0: G, 1: H
        elem_cfg_t [NUM_ELEM-1:0] elem;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    // effective operating mode of one element, {latch, edge_neg}
    typedef enum logic [1:0] {
        MODE_FF_RISE  = 2'd0,
        MODE_FF_FALL  = 2'd1,
        MODE_LAT_HIGH = 2'd2,
        MODE_LAT_LOW  = 2'd3
    } store_mode_e;

endpackage

// File: rtl/lcell_cfg_hold.sv
module lcell_cfg_hold
    import lcell_pkg::*;
(
    input  logic             por_n,
    input  logic             load,
    input  logic [CFG_W-1:0] word,
    output cell_cfg_t        cfg_q
);

    // level-held: transparent while load is high, cleared at power-up
    always_latch begin
        if (!por_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cell_cfg_t'(word);
        end
    end

endmodule

// File: rtl/lcell_route.sv
module lcell_route
    import lcell_pkg::*;
(
    input  logic [NUM_GP-1:0] gp_ctl,
    input  cell_cfg_t         cfg,
    input  logic              lut_f,
    input  logic              lut_g,
    input  logic              lut_h,
    output logic              ctl_h1,
    output logic              ctl_din,
    output logic              ctl_sr,
    output logic              ctl_ec,
    output logic              out_x,
    output logic              out_y
);

    // any general input may drive any internal control
    always_comb begin
        ctl_h1  = gp_ctl[cfg.sel_h1];
        ctl_din = gp_ctl[cfg.sel_din];
        ctl_sr  = gp_ctl[cfg.sel_sr];
        ctl_ec  = gp_ctl[cfg.sel_ec];
    end

    // combinational outputs pick between a dedicated table and H
    always_comb begin
        out_x = cfg.xsel ? lut_h : lut_f;
        out_y = cfg.ysel ? lut_h : lut_g;
    end

endmodule

// File: rtl/lcell_store.sv
module lcell_store
    import lcell_pkg::*;
(
    input  logic      clk,
    input  logic      force_async,
    input  elem_cfg_t ecfg,
    input  logic      lut_f,
    input  logic      lut_g,
    input  logic      lut_h,
    input  logic      din,
    input  logic      sr_in,
    input  logic      ec_in,
    output logic      q,
    output logic      hold,
    output logic      ce,
    output logic      d
);

    logic        clk_int;
    logic        ff_q;
    logic        lat_q;
    store_mode_e mode;

    // 4:1 data selector
    always_comb begin
        unique case (ecfg.dsel)
            DSRC_F:   d = lut_f;
            DSRC_G:   d = lut_g;
            DSRC_H:   d = lut_h;
            DSRC_DIN: d = din;
        endcase
    end

    // unconnected enable defaults active, unconnected set/reset inactive
    assign ce      = ecfg.ec_conn ? ec_in : 1'b1;
    assign hold    = force_async | (ecfg.sr_conn & sr_in);
    assign clk_int = clk ^ ecfg.edge_neg;

    // edge-triggered storage; forced value wins over clock and enable
    always_ff @(posedge clk_int or posedge hold) begin
        if (hold) begin
            ff_q <= ecfg.sr_set;
        end else if (ce) begin
            ff_q <= d;
        end
    end

    // level-sensitive storage
    always_latch begin
        if (hold) begin
            lat_q <= ecfg.sr_set;
        end else if (clk_int && ce) begin
            lat_q <= d;
        end
    end

    assign mode = store_mode_e'({ecfg.latch, ecfg.edge_neg});

    always_comb begin
        unique case (mode)
            MODE_FF_RISE, MODE_FF_FALL:   q = ff_q;
            MODE_LAT_HIGH, MODE_LAT_LOW:  q = lat_q;
        endcase
    end

endmodule

// File: rtl/lcell_regstage.sv
module lcell_regstage
    import lcell_pkg::*;
(
    input  logic              por_n,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              cell_clk,
    input  logic              gsr,
    input  logic              lut_f,
    input  logic              lut_g,
    input  logic              lut_h,
    input  logic [NUM_GP-1:0] gp_ctl,
    output logic              out_x,
    output logic              out_y,
    output logic [NUM_ELEM-1:0] reg_q,
    output logic              ctl_h1,
    output logic              ctl_din,
    output logic              ctl_sr,
    output logic              ctl_ec
);

    cell_cfg_t            cfg_q;
    logic                 force_async;
    logic [NUM_ELEM-1:0]  hold_v;
    logic [NUM_ELEM-1:0]  ce_v;
    logic [NUM_ELEM-1:0]  d_v;

    assign force_async = gsr | ~por_n;

    lcell_cfg_hold u_cfg (
        .por_n (por_n),
        .load  (cfg_load),
        .word  (cfg_word),
        .cfg_q (cfg_q)
    );

    lcell_route u_route (
        .gp_ctl  (gp_ctl),
        .cfg     (cfg_q),
        .lut_f   (lut_f),
        .lut_g   (lut_g),
        .lut_h   (lut_h),
        .ctl_h1  (ctl_h1),
        .ctl_din (ctl_din),
        .ctl_sr  (ctl_sr),
        .ctl_ec  (ctl_ec),
        .out_x   (out_x),
        .out_y   (out_y)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        lcell_store u_store (
            .clk         (cell_clk),
            .force_async (force_async),
            .ecfg        (cfg_q.elem[e]),
            .lut_f       (lut_f),
            .lut_g       (lut_g),
            .lut_h       (lut_h),
            .din         (ctl_din),
            .sr_in       (ctl_sr),
            .ec_in       (ctl_ec),
            .q           (reg_q[e]),
            .hold        (hold_v[e]),
            .ce          (ce_v[e]),
            .d           (d_v[e])
        );
    end

endmodule

// File: rtl/lcell_regstage_chk.sv
module lcell_regstage_chk
    import lcell_pkg::*;
(
    input logic                cell_clk,
    input logic                por_n,
    input logic                gsr,
    input logic                ctl_sr,
    input cell_cfg_t           cfg,
    input logic [NUM_ELEM-1:0] reg_q,
    input logic [NUM_ELEM-1:0] hold_v,
    input logic [NUM_ELEM-1:0] ce_v,
    input logic [NUM_ELEM-1:0] d_v
);

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_chk
        logic cap_valid;
        logic cap_d;
        logic cap_q;
        logic cap_en;

        // snapshot at each rising edge for rising-edge flip-flop elements
        always_ff @(posedge cell_clk or posedge hold_v[e]) begin
            if (hold_v[e]) begin
                cap_valid <= 1'b0;
                cap_d     <= 1'b0;
                cap_q     <= 1'b0;
                cap_en    <= 1'b0;
            end else begin
                cap_valid <= por_n && !cfg.elem[e].latch && !cfg.elem[e].edge_neg;
                cap_d     <= d_v[e];
                cap_q     <= reg_q[e];
                cap_en    <= ce_v[e];
            end
        end

        AST_RISE_CAPTURE: assert property (@(negedge cell_clk) disable iff (!por_n || hold_v[e])
            (cap_valid && cap_en) |-> (reg_q[e] == cap_d)); // R2

        AST_ENABLE_LOW_HOLD: assert property (@(negedge cell_clk) disable iff (!por_n || hold_v[e])
            (cap_valid && !cap_en) |-> (reg_q[e] == cap_q)); // R5

        AST_SR_FORCE: assert property (@(negedge cell_clk) disable iff (!por_n)
            (cfg.elem[e].sr_conn && ctl_sr) |-> (reg_q[e] == cfg.elem[e].sr_set)); // R6

        AST_GSR_FORCE: assert property (@(negedge cell_clk) disable iff (!por_n)
            gsr |-> (reg_q[e] == cfg.elem[e].sr_set)); // R7
    end

endmodule

bind lcell_regstage lcell_regstage_chk u_chk (
    .cell_clk (cell_clk),
    .por_n    (por_n),
    .gsr      (gsr),
    .ctl_sr   (ctl_sr),
    .cfg      (cfg_q),
    .reg_q    (reg_q),
    .hold_v   (hold_v),
    .ce_v     (ce_v),
    .d_v      (d_v)
);

// File: tb/lcell_regstage_bench.sv
module lcell_regstage_bench;
    import lcell_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic              por_n;
    logic              cfg_load;
    logic [CFG_W-1:0]  cfg_word;
    logic              cell_clk;
    logic              gsr;
    logic              lut_f;
    logic              lut_g;
    logic              lut_h;
    logic [NUM_GP-1:0] gp_ctl;
    logic              out_x;
    logic              out_y;
    logic [NUM_ELEM-1:0] reg_q;
    logic              ctl_h1;
    logic              ctl_din;
    logic              ctl_sr;
    logic              ctl_ec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    lcell_regstage u_lcell_regstage (
        .por_n    (por_n),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .cell_clk (cell_clk),
        .gsr      (gsr),
        .lut_f    (lut_f),
        .lut_g    (lut_g),
        .lut_h    (lut_h),
        .gp_ctl   (gp_ctl),
        .out_x    (out_x),
        .out_y    (out_y),
        .reg_q    (reg_q),
        .ctl_h1   (ctl_h1),
        .ctl_din  (ctl_din),
        .ctl_sr   (ctl_sr),
        .ctl_ec   (ctl_ec)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edge_up();
        #HALF cell_clk = 1'b1;
        #HALF;
    endtask

    task automatic edge_dn();
        #HALF cell_clk = 1'b0;
        #HALF;
    endtask

    // load with the clock low, then re-initialise both elements
    task automatic load_cfg(input cell_cfg_t c);
        cfg_word = CFG_W'(c);
        cfg_load = 1'b1;
        #1 cfg_load = 1'b0;
        #1 gsr = 1'b1;
        #1 gsr = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        por_n = 1'b0; gsr = 1'b0; cfg_load = 1'b0; cfg_word = '1;
        lut_f = 1'b1; lut_g = 1'b0; lut_h = 1'b1; gp_ctl = 4'b1010;
        #2;
        chk("R1 q at power-up", 4'(reg_q), 4'd0);
        chk("R1 x=F", 4'(out_x), 4'd1);
        chk("R1 y=G", 4'(out_y), 4'd0);
        chk("R1 routes gp0", {ctl_h1, ctl_din, ctl_sr, ctl_ec}, 4'b0000);
        gp_ctl = 4'b0101; #1;
        chk("R1 routes gp0 high", {ctl_h1, ctl_din, ctl_sr, ctl_ec}, 4'b1111);
        edge_up(); edge_dn();
        chk("R1 q held through clock", 4'(reg_q), 4'd0);
        cfg_word = '0;
        por_n = 1'b1; gp_ctl = 4'b0000; #2;
    endtask

    task automatic t_cfg_gate();
        cell_cfg_t c;
        c = '0; c.xsel = 1'b1;
        load_cfg(c);
        lut_f = 1'b0; lut_h = 1'b1; #1;
        chk("R11 loaded xsel", 4'(out_x), 4'd1);
        cfg_word = '0; #2;
        chk("R11 word ignored without strobe", 4'(out_x), 4'd1);
        load_cfg('0); #1;
        chk("R11 reload takes effect", 4'(out_x), 4'd0);
    endtask

    task automatic t_comb();
        for (int s = 0; s < 4; s++) begin
            cell_cfg_t c;
            c = '0; c.xsel = s[0]; c.ysel = s[1];
            load_cfg(c);
            for (int v = 0; v < 8; v++) begin
                lut_f = v[0]; lut_g = v[1]; lut_h = v[2]; #1;
                chk("R9 x", 4'(out_x), 4'(s[0] ? v[2] : v[0]));
                chk("R9 y", 4'(out_y), 4'(s[1] ? v[2] : v[1]));
            end
        end
    endtask

    task automatic t_route();
        for (int s = 0; s < 4; s++) begin
            cell_cfg_t c;
            c = '0;
            c.sel_h1  = 2'(s);
            c.sel_din = 2'(s + 1);
            c.sel_sr  = 2'(s + 2);
            c.sel_ec  = 2'(s + 3);
            load_cfg(c);
            for (int g = 0; g < 16; g++) begin
                gp_ctl = 4'(g); #1;
                chk("R10 h1",  4'(ctl_h1),  4'(g >> (s % 4)) & 4'd1);
                chk("R10 din", 4'(ctl_din), 4'(g >> ((s + 1) % 4)) & 4'd1);
                chk("R10 sr",  4'(ctl_sr),  4'(g >> ((s + 2) % 4)) & 4'd1);
                chk("R10 ec",  4'(ctl_ec),  4'(g >> ((s + 3) % 4)) & 4'd1);
            end
        end
        gp_ctl = '0;
    endtask

    task automatic t_rise();
        for (int ds = 0; ds < 4; ds++) begin
            cell_cfg_t c;
            c = '0; c.sel_din = 2'd1;
            c.elem[0].dsel = dsrc_e'(ds);
            c.elem[1].dsel = dsrc_e'(3 - ds);
            load_cfg(c);
            for (int v = 0; v < 2; v++) begin
                logic b;
                b = v[0];
                lut_f = (ds == 0) ? b : !b;
                lut_g = (ds == 1) ? b : !b;
                lut_h = (ds == 2) ? b : !b;
                gp_ctl = {2'b00, ((ds == 3) ? b : !b), 1'b0};
                edge_up();
                chk("R4 selected source elem0", 4'(reg_q[0]), 4'(b));
                chk("R4 other source elem1", 4'(reg_q[1]), 4'(!b));
                lut_f = !lut_f; lut_g = !lut_g; lut_h = !lut_h; gp_ctl = gp_ctl ^ 4'b0010;
                edge_dn();
                chk("R2 falling edge ignored", 4'(reg_q), {2'b00, !b, b});
            end
        end
        gp_ctl = '0;
    endtask

    task automatic t_fall();
        cell_cfg_t c;
        c = '0; c.elem[0].edge_neg = 1'b1;
        load_cfg(c);
        lut_f = 1'b1;
        edge_up();
        chk("R3 rising ignored by falling elem", 4'(reg_q), 4'b0010);
        edge_dn();
        chk("R3 falling captures", 4'(reg_q), 4'b0011);
        lut_f = 1'b0;
        edge_up();
        chk("R3 rising ignored again", 4'(reg_q), 4'b0001);
        edge_dn();
        chk("R3 falling captures 0", 4'(reg_q), 4'b0000);
    endtask

    task automatic t_enable();
        cell_cfg_t c;
        c = '0; c.sel_ec = 2'd2; c.elem[0].ec_conn = 1'b1;
        load_cfg(c);
        gp_ctl = 4'b0000; lut_f = 1'b1;
        edge_up(); edge_dn();
        chk("R5 enable low holds, unconnected loads", 4'(reg_q), 4'b0010);
        gp_ctl = 4'b0100;
        edge_up(); edge_dn();
        chk("R5 enable high loads", 4'(reg_q), 4'b0011);
        gp_ctl = 4'b0000; lut_f = 1'b0;
        edge_up(); edge_dn();
        chk("R5 enable low again holds", 4'(reg_q), 4'b0001);
        gp_ctl = '0;
    endtask

    task automatic t_sr();
        cell_cfg_t c;
        c = '0; c.sel_sr = 2'd3;
        c.elem[0].sr_conn = 1'b1; c.elem[0].sr_set = 1'b1;
        c.elem[1].sr_conn = 1'b1;
        load_cfg(c);
        chk("R6 init after gsr", 4'(reg_q), 4'b0001);
        lut_f = 1'b0;
        edge_up(); edge_dn();
        chk("R6 clocked to 0", 4'(reg_q), 4'b0000);
        gp_ctl = 4'b1000; #2;
        chk("R6 async force without clock", 4'(reg_q), 4'b0001);
        lut_f = 1'b1;
        edge_up(); edge_dn();
        chk("R6 force beats clock", 4'(reg_q), 4'b0001);
        gp_ctl = 4'b0000; #2;
        chk("R6 release holds", 4'(reg_q), 4'b0001);
        edge_up(); edge_dn();
        chk("R6 clock after release", 4'(reg_q), 4'b0011);
        c.elem[0].sr_conn = 1'b0; c.elem[1].sr_conn = 1'b0;
        load_cfg(c);
        gp_ctl = 4'b1000; lut_f = 1'b0;
        edge_up(); edge_dn();
        chk("R6 unconnected set/reset ignored", 4'(reg_q), 4'b0000);
        gp_ctl = '0;
    endtask

    task automatic t_gsr();
        cell_cfg_t c;
        c = '0; c.elem[0].sr_set = 1'b1;
        load_cfg(c);
        lut_f = 1'b0;
        edge_up(); edge_dn();
        chk("R7 clocked to 0", 4'(reg_q), 4'b0000);
        gsr = 1'b1; #2;
        chk("R7 per-element value", 4'(reg_q), 4'b0001);
        lut_f = 1'b1;
        edge_up(); edge_dn();
        chk("R7 holds through clock", 4'(reg_q), 4'b0001);
        gsr = 1'b0; #1;
        edge_up(); edge_dn();
        chk("R7 released, clock loads", 4'(reg_q), 4'b0011);
    endtask

    task automatic t_latch();
        cell_cfg_t c;
        c = '0; c.sel_ec = 2'd2;
        c.elem[0].latch = 1'b1; c.elem[0].ec_conn = 1'b1;
        c.elem[1].latch = 1'b1; c.elem[1].edge_neg = 1'b1;
        gp_ctl = 4'b0100; lut_f = 1'b0;
        load_cfg(c);
        lut_f = 1'b1; #2;
        chk("R8 low-transparent follows", 4'(reg_q), 4'b0010);
        cell_clk = 1'b1; #2;
        chk("R8 high-transparent opens", 4'(reg_q), 4'b0011);
        lut_f = 1'b0; #2;
        chk("R8 follow vs hold", 4'(reg_q), 4'b0010);
        cell_clk = 1'b0; #2;
        chk("R8 swap open latch", 4'(reg_q), 4'b0000);
        lut_f = 1'b1; #2;
        chk("R8 closed holds", 4'(reg_q), 4'b0010);
        gp_ctl = 4'b0000; cell_clk = 1'b1; #2;
        chk("R8 enable low keeps closed", 4'(reg_q), 4'b0010);
        gp_ctl = 4'b0100; #2;
        chk("R8 enable opens", 4'(reg_q), 4'b0011);
        cell_clk = 1'b0; gp_ctl = '0; #2;
    endtask

    initial begin
        cell_clk = 1'b0;
        t_reset();
        t_cfg_gate();
        t_comb();
        t_route();
        t_rise();
        t_fall();
        t_enable();
        t_sr();
        t_gsr();
        t_latch();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule